// File: doc/BRIEF.md
# Runahead Poison Tracker

During runahead execution a load that missed the cache retires with a placeholder value, and every result that descends from that value is garbage. This block keeps one poison bit per physical register so the pipeline knows which in-flight values are garbage. A missing load marks its destination through the writeback port. Each dispatched instruction then takes the OR of the poison bits of the sources it reads, and that result is written into its destination bit.

At dispatch the block also tells the memory pipeline whether a load or store may go to the cache. An operation whose address comes from a poisoned register is held back, so no access is made with a wrong address. A load-independent access still goes out, and a miss there warms the cache for the later replay. Leaving runahead, or pulsing the clear input, wipes every bit in one cycle.

Top module: `poison_tracker`

## Requirements
- R1: After reset every poison bit is clear, `disp_poison_o` is 0 and `mem_permit_o` is 1.
- R2: While `runahead_i` is low, `mem_permit_o` is 1 and `disp_poison_o` is 0 in every cycle. All poison bits become clear at the next edge, and no dispatch or writeback records anything.
- R3: In runahead, a writeback with `wb_valid_i` and `wb_miss_i` high poisons register `wb_tag_i` from the next cycle onward.
- R4: In runahead, `disp_poison_o` is the OR of the poison bits of the sources whose use flags are set, with the same cycle. When `disp_dst_valid_i` is high, that value is written to register `disp_dst_i` at the next edge.
- R5: A dispatch in runahead that writes a destination and has no poisoned source clears that register's bit.
- R6: Op codes are 2'b00 ALU, 2'b01 load, 2'b10 store and 2'b11 other. A load in runahead gets `mem_permit_o` = 0 exactly when its address source (source A) is used and poisoned. Non-memory ops always get 1.
- R7: A store's permit depends only on source A (address). The poison on source B (data) never blocks it, but it does still propagate into `disp_poison_o`.
- R8: `clear_all_i` clears every poison bit at the next edge, and takes priority over a dispatch or writeback in the same cycle.
- R9: A source tag that equals the tag of a missing writeback in the same cycle is treated as poisoned.
- R10: If a dispatch destination and a missing writeback name the same register in one cycle, that bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runahead_i | input | 1 | Runahead mode active |
| clear_all_i | input | 1 | Clear all poison bits |
| disp_valid_i | input | 1 | Dispatch slot valid |
| disp_op_i | input | 2 | Op class: 00 ALU, 01 load, 10 store, 11 other |
| disp_use_a_i | input | 1 | Source A (address for memory ops) is read |
| disp_src_a_i | input | TAG_W | Source A physical tag |
| disp_use_b_i | input | 1 | Source B (store data / second operand) is read |
| disp_src_b_i | input | TAG_W | Source B physical tag |
| disp_dst_valid_i | input | 1 | Instruction writes a destination |
| disp_dst_i | input | TAG_W | Destination physical tag |
| wb_valid_i | input | 1 | Writeback valid |
| wb_miss_i | input | 1 | Writeback is a load that missed (bogus value) |
| wb_tag_i | input | TAG_W | Writeback physical tag |
| disp_poison_o | output | 1 | Poison of the dispatched instruction's result |
| mem_permit_o | output | 1 | Dispatched memory op may access the cache |

## Verification
A wrong poison bit is not visible when it is written. It shows up only when a later dispatch reads that register: as a wrong `disp_poison_o` for any op, or as a wrong `mem_permit_o` for a load or store that uses it as an address. The delay can therefore be as short as one cycle after the write or as long as the gap until the next reader. For that reason the bench re-reads registers it has just poisoned or cleaned, and it also runs long random streams on a small register file so that tags collide often.

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int NUM_PREGS = 64,
  parameter int TAG_W = $clog2(NUM_PREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runahead_i,
  input  logic             clear_all_i,
  input  logic             disp_valid_i,
  input  logic [1:0]       disp_op_i,
  input  logic             disp_use_a_i,
  input  logic [TAG_W-1:0] disp_src_a_i,
  input  logic             disp_use_b_i,
  input  logic [TAG_W-1:0] disp_src_b_i,
  input  logic             disp_dst_valid_i,
  input  logic [TAG_W-1:0] disp_dst_i,
  input  logic             wb_valid_i,
  input  logic             wb_miss_i,
  input  logic [TAG_W-1:0] wb_tag_i,
  output logic             disp_poison_o,
  output logic             mem_permit_o
);
  localparam logic [1:0] OP_LOAD  = 2'b01;
  localparam logic [1:0] OP_STORE = 2'b10;

  logic [NUM_PREGS-1:0] poison_q;
  logic [NUM_PREGS-1:0] poison_d;
  logic wb_set, a_bad, b_bad, is_mem;

  assign wb_set = runahead_i && wb_valid_i && wb_miss_i;
  assign a_bad  = disp_use_a_i &&
                  (poison_q[disp_src_a_i] || (wb_set && wb_tag_i == disp_src_a_i));
  assign b_bad  = disp_use_b_i &&
                  (poison_q[disp_src_b_i] || (wb_set && wb_tag_i == disp_src_b_i));
  assign is_mem = (disp_op_i == OP_LOAD) || (disp_op_i == OP_STORE);

  assign disp_poison_o = runahead_i && disp_valid_i && (a_bad || b_bad);
  assign mem_permit_o  = !runahead_i || !disp_valid_i || !is_mem || !a_bad;

  always_comb begin
    poison_d = poison_q;
    if (runahead_i && disp_valid_i && disp_dst_valid_i)
      poison_d[disp_dst_i] = disp_poison_o;
    if (wb_set)
      poison_d[wb_tag_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all_i || !runahead_i)
      poison_q <= '0;
    else
      poison_q <= poison_d;
  end
endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
  parameter int NUM_PREGS = 64,
  parameter int TAG_W = $clog2(NUM_PREGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             runahead_i,
  input logic             clear_all_i,
  input logic             disp_valid_i,
  input logic             disp_dst_valid_i,
  input logic [TAG_W-1:0] disp_dst_i,
  input logic             wb_valid_i,
  input logic             wb_miss_i,
  input logic [TAG_W-1:0] wb_tag_i,
  input logic             disp_poison_o,
  input logic             mem_permit_o,
  input logic [NUM_PREGS-1:0] poison_q
);
  p_permit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !runahead_i |-> (mem_permit_o && !disp_poison_o));

  p_idle_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !runahead_i |=> (poison_q == '0));

  p_miss_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (runahead_i && !clear_all_i && wb_valid_i && wb_miss_i) |=> poison_q[$past(wb_tag_i)]);

  p_prop_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (runahead_i && !clear_all_i && disp_valid_i && disp_dst_valid_i && disp_poison_o)
      |=> poison_q[$past(disp_dst_i)]);

  p_clean_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (runahead_i && !clear_all_i && disp_valid_i && disp_dst_valid_i && !disp_poison_o &&
     !(wb_valid_i && wb_miss_i && wb_tag_i == disp_dst_i))
      |=> !poison_q[$past(disp_dst_i)]);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all_i |=> (poison_q == '0));
endmodule

bind poison_tracker poison_tracker_chk #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/tb_poison_tracker.sv
`timescale 1ns/1ps
module tb_poison_tracker;
  localparam int N = 16;
  localparam int TW = 4;

  logic clk = 0, rst_n = 0;
  logic runahead_i = 0, clear_all_i = 0, disp_valid_i = 0;
  logic [1:0] disp_op_i = 0;
  logic disp_use_a_i = 0, disp_use_b_i = 0, disp_dst_valid_i = 0;
  logic [TW-1:0] disp_src_a_i = 0, disp_src_b_i = 0, disp_dst_i = 0, wb_tag_i = 0;
  logic wb_valid_i = 0, wb_miss_i = 0;
  logic disp_poison_o, mem_permit_o;

  int vectors = 0, errors = 0, cycles = 0;
  bit mdl [N];

  always #2.5 clk = ~clk;

  poison_tracker #(.NUM_PREGS(N)) dut (.*);

  task automatic check(string req, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Apply current inputs for one cycle: compare against the model, then advance it.
  task automatic step(string req);
    bit wbs, pa, pb, ep, eperm, mem;
    #1;
    wbs = runahead_i && wb_valid_i && wb_miss_i;
    pa = disp_use_a_i && (mdl[disp_src_a_i] || (wbs && wb_tag_i == disp_src_a_i));
    pb = disp_use_b_i && (mdl[disp_src_b_i] || (wbs && wb_tag_i == disp_src_b_i));
    mem = (disp_op_i == 2'b01) || (disp_op_i == 2'b10);
    ep = runahead_i && disp_valid_i && (pa || pb);
    eperm = !(runahead_i && disp_valid_i && mem && pa);
    check(req, disp_poison_o, ep, "poison");
    check(req, mem_permit_o, eperm, "permit");
    @(posedge clk);
    if (!rst_n || clear_all_i || !runahead_i) begin
      foreach (mdl[i]) mdl[i] = 0;
    end else begin
      if (disp_valid_i && disp_dst_valid_i) mdl[disp_dst_i] = ep;
      if (wbs) mdl[wb_tag_i] = 1;
    end
    @(negedge clk);
    cycles++;
  endtask

  task automatic idle();
    disp_valid_i = 0; wb_valid_i = 0; wb_miss_i = 0; clear_all_i = 0;
    disp_use_a_i = 0; disp_use_b_i = 0; disp_dst_valid_i = 0; disp_op_i = 0;
  endtask

  task automatic disp(logic [1:0] op, logic ua, int a, logic ub, int b, logic dv, int d);
    disp_valid_i = 1; disp_op_i = op;
    disp_use_a_i = ua; disp_src_a_i = TW'(a);
    disp_use_b_i = ub; disp_src_b_i = TW'(b);
    disp_dst_valid_i = dv; disp_dst_i = TW'(d);
  endtask

  task automatic wb(int t, logic miss);
    wb_valid_i = 1; wb_miss_i = miss; wb_tag_i = TW'(t);
  endtask

  task automatic probe(string req, int t, logic exp);
    idle(); disp(2'b01, 1, t, 0, 0, 0, 0);
    #1;
    check(req, disp_poison_o, exp, "probe poison");
    check(req, mem_permit_o, !exp, "probe permit");
    step(req); idle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000 || $time > 1000000) begin
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    foreach (mdl[i]) mdl[i] = 0;
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    // R1: reset state, seen through a load probe outside runahead
    idle(); disp(2'b01, 1, 3, 1, 4, 1, 5); step("R1");
    // R2: activity outside runahead records nothing
    idle(); wb(6, 1); disp(2'b10, 1, 6, 0, 0, 0, 0); step("R2");
    runahead_i = 1; idle(); step("R2");
    probe("R2", 6, 0);
    // R3: missing writeback poisons its tag
    idle(); wb(2, 1); step("R3");
    probe("R3", 2, 1);
    // R4: propagation through a chain
    idle(); disp(2'b00, 1, 7, 1, 2, 1, 8); step("R4");
    idle(); disp(2'b00, 1, 8, 0, 0, 1, 9); step("R4");
    probe("R4", 9, 1);
    // R6: load with clean address permitted, poisoned address blocked
    idle(); disp(2'b01, 1, 7, 0, 0, 1, 10); step("R6");
    idle(); disp(2'b01, 1, 9, 0, 0, 1, 11); step("R6");
    probe("R6", 11, 1);
    // R7: store with poisoned data but clean address is permitted
    idle(); disp(2'b10, 1, 7, 1, 9, 0, 0); #1;
    check("R7", mem_permit_o, 1, "store permit"); step("R7");
    idle(); disp(2'b10, 1, 9, 1, 7, 0, 0); #1;
    check("R7", mem_permit_o, 0, "store blocked"); step("R7");
    // R5: clean write clears a poisoned register
    idle(); disp(2'b00, 1, 7, 0, 0, 1, 9); step("R5");
    probe("R5", 9, 0);
    // R9: same-cycle bypass from a missing writeback
    idle(); wb(12, 1); disp(2'b01, 1, 12, 0, 0, 1, 13); #1;
    check("R9", mem_permit_o, 0, "bypass permit"); step("R9");
    probe("R9", 13, 1);
    // R10: dispatch clean write and missing writeback to the same tag
    idle(); wb(14, 1); disp(2'b00, 1, 7, 0, 0, 1, 14); step("R10");
    probe("R10", 14, 1);
    // R8: clear_all beats a same-cycle set
    idle(); wb(3, 1); clear_all_i = 1; step("R8");
    probe("R8", 3, 0);
    probe("R8", 2, 0);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      idle();
      runahead_i = ($urandom_range(0, 40) != 0);
      clear_all_i = ($urandom_range(0, 60) == 0);
      if ($urandom_range(0, 3) != 0)
        disp(2'($urandom), 1'($urandom), $urandom_range(0, N-1), 1'($urandom),
             $urandom_range(0, N-1), 1'($urandom), $urandom_range(0, N-1));
      if ($urandom_range(0, 2) == 0) wb($urandom_range(0, N-1), ($urandom_range(0, 3) == 0));
      if (!runahead_i) step("R2");
      else if (disp_op_i == 2'b10) step("R7");
      else if (disp_op_i == 2'b01) step("R6");
      else step("R4");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule